// File: doc/BRIEF.md
# Posted Store Buffer with Bus Fault Classification

This block sits between a processor's store port and a simple valid/ready system bus. It holds one store at a time. For every store it works out whether the target memory is bufferable. It uses a fixed default address map, or one programmable protection region when protection is switched on. A bufferable store is acknowledged to the core straight away and is written to the bus afterwards. A non-bufferable store keeps the core waiting until the bus has finished the write.

The bufferable attribute also decides how a bus error is reported. An error on a held store is precise: it is tied to the stalled store, and the store's address is recorded. An error on a posted store is imprecise: the core has already moved on, so only a flag is set. Both flags are sticky and are cleared by writing one. A one-cycle fault pulse marks every error that is logged. The internal SRAM window never produces bus errors, so an error response for an SRAM store is discarded.

Top module: `stb_post_buffer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `st_ack`, `bus_valid`, `flt_precise`, `flt_imprecise`, `flt_addr_valid` and `fault_pulse` are all low.
- R2: The default map marks addresses 0x2000_0000 to 0x3FFF_FFFF (the SRAM window) as bufferable and marks every other address as non-bufferable.
- R3: When `cfg_prot_en` is high and `cfg_rgn_lo <= st_addr <= cfg_rgn_hi`, `cfg_rgn_buf` replaces the default attribute. Otherwise the default map applies. A typical region is the peripheral window 0x4000_0000 to 0x5FFF_FFFF.
- R4: A store is captured at the clock edge where `st_valid` is high, the buffer is empty and `st_ack` is low. For a bufferable store, `st_ack` is high in the following cycle, whatever the bus does, and `bus_valid` rises in that same cycle.
- R5: For a non-bufferable store, `st_ack` stays low until the bus completes (`bus_valid && bus_ready`). It is then high in the cycle after completion.
- R6: `bus_valid`, `bus_addr` and `bus_data` stay unchanged until `bus_ready` is seen. A store that arrives while the entry is still draining gets no `st_ack` and is not captured until the entry is free, so stores reach the bus in program order.
- R7: A bus error on a bufferable store sets `flt_imprecise` (clear bit 1). It does not change `flt_addr` or `flt_addr_valid`.
- R8: A bus error on a non-bufferable store sets `flt_precise` (clear bit 0), loads the store address into `flt_addr` and sets `flt_addr_valid`. These become visible in the same cycle as the store's `st_ack`.
- R9: A bus error response for a store whose address lies in the SRAM window is ignored: no flag, no pulse and no address change.
- R10: `fault_pulse` is high for exactly the one cycle after each completion that logs an error (R7 or R8), and is low otherwise.
- R11: Each flag is sticky. It is cleared by a one on its bit of `flt_clr` (bit 0 precise, bit 1 imprecise), and clearing precise also clears `flt_addr_valid`. A new error beats a clear in the same cycle. A precise error while `flt_precise` is already set keeps the first address.
- R12: `st_ack` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core presents a store; held until acknowledged |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_ack | output | 1 | One-cycle store acknowledge to the core |
| cfg_prot_en | input | 1 | Protection region enable |
| cfg_rgn_lo | input | AW | Region lower bound, inclusive |
| cfg_rgn_hi | input | AW | Region upper bound, inclusive |
| cfg_rgn_buf | input | 1 | Bufferable attribute of the region |
| bus_valid | output | 1 | Bus write request |
| bus_addr | output | AW | Bus write address |
| bus_data | output | DW | Bus write data |
| bus_ready | input | 1 | Bus write completes this cycle |
| bus_err | input | 1 | Error response, sampled with bus_ready |
| flt_clr | input | 2 | Write-one-to-clear strobes: bit 0 precise, bit 1 imprecise |
| flt_precise | output | 1 | Sticky precise bus fault flag |
| flt_imprecise | output | 1 | Sticky imprecise bus fault flag |
| flt_addr | output | AW | Address of the first precise fault |
| flt_addr_valid | output | 1 | flt_addr holds a valid fault address |
| fault_pulse | output | 1 | One-cycle pulse for each logged bus error |

## Verification
The two functions that can land in the same cycle are logging a bus error and a software clear of the same flag. The bench raises `flt_clr` in the very cycle where a failing write completes, once for a held store and once for a posted store. It then expects the flag to be set afterwards. A second pairing is a new store that arrives while a posted store is still draining. The bench leaves the second request pending over several stalled bus cycles and checks that the acknowledge stays low, that the bus address stays fixed, and that the second store reaches the bus only after the first one completes.

// File: rtl/stb_pkg.sv
`timescale 1ns/1ps
package stb_pkg;

  // Drain controller states
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_POSTED = 2'd1,
    ST_HELD   = 2'd2
  } stb_state_e;

  // Fault flag register; bit positions match the clear strobe
  typedef struct packed {
    logic imprecise;
    logic precise;
  } flt_flags_t;

endpackage

// File: rtl/stb_attr_lookup.sv
`timescale 1ns/1ps
module stb_attr_lookup #(
  parameter int          AW           = 32,
  parameter logic [AW-1:0] SRAM_LO    = 'h2000_0000,
  parameter logic [AW-1:0] SRAM_HI    = 'h3FFF_FFFF,
  parameter bit          PROT_PRESENT = 1'b1
) (
  input  logic [AW-1:0] addr,
  input  logic          prot_en,
  input  logic [AW-1:0] rgn_lo,
  input  logic [AW-1:0] rgn_hi,
  input  logic          rgn_buf,
  output logic          buf_attr,
  output logic          err_masked
);

  logic in_sram;
  logic rgn_hit;

  assign in_sram = (addr >= SRAM_LO) && (addr <= SRAM_HI);

  generate
    if (PROT_PRESENT) begin : g_rgn
      assign rgn_hit = prot_en && (addr >= rgn_lo) && (addr <= rgn_hi);
    end else begin : g_no_rgn
      assign rgn_hit = 1'b0;
    end
  endgenerate

  // Region attribute has priority over the default map
  assign buf_attr   = rgn_hit ? rgn_buf : in_sram;
  // SRAM never signals bus errors; discard any such response
  assign err_masked = in_sram;

endmodule

// File: rtl/stb_drain_ctrl.sv
`timescale 1ns/1ps
module stb_drain_ctrl
  import stb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          attr_buf,
  input  logic          attr_mask,
  output logic          st_ack,
  output logic          bus_valid,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  input  logic          bus_ready,
  input  logic          bus_err,
  output logic          ev_prec,
  output logic          ev_imp,
  output logic [AW-1:0] ev_addr
);

  stb_state_e state;
  logic       ent_buf;
  logic       ent_mask;
  logic       done;
  logic       err_eff;

  assign done    = bus_valid && bus_ready;
  assign err_eff = done && bus_err && !ent_mask;
  assign ev_prec = err_eff && !ent_buf;
  assign ev_imp  = err_eff && ent_buf;
  assign ev_addr = bus_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      st_ack    <= 1'b0;
      bus_valid <= 1'b0;
      bus_addr  <= '0;
      bus_data  <= '0;
      ent_buf   <= 1'b0;
      ent_mask  <= 1'b0;
    end else begin
      st_ack <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (st_valid && !st_ack) begin
            bus_valid <= 1'b1;
            bus_addr  <= st_addr;
            bus_data  <= st_data;
            ent_buf   <= attr_buf;
            ent_mask  <= attr_mask;
            if (attr_buf) begin
              st_ack <= 1'b1;
              state  <= ST_POSTED;
            end else begin
              state  <= ST_HELD;
            end
          end
        end
        ST_POSTED: begin
          if (bus_ready) begin
            bus_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        ST_HELD: begin
          if (bus_ready) begin
            bus_valid <= 1'b0;
            st_ack    <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stb_fault_log.sv
`timescale 1ns/1ps
module stb_fault_log
  import stb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_prec,
  input  logic          ev_imp,
  input  logic [AW-1:0] ev_addr,
  input  logic [1:0]    clr,
  output logic          prec,
  output logic          imp,
  output logic [AW-1:0] addr,
  output logic          addr_valid,
  output logic          pulse
);

  flt_flags_t flags;
  flt_flags_t clr_s;

  assign clr_s = flt_flags_t'(clr);
  assign prec  = flags.precise;
  assign imp   = flags.imprecise;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags      <= '0;
      addr       <= '0;
      addr_valid <= 1'b0;
      pulse      <= 1'b0;
    end else begin
      pulse           <= ev_prec | ev_imp;
      flags.precise   <= ev_prec | (flags.precise & ~clr_s.precise);
      flags.imprecise <= ev_imp | (flags.imprecise & ~clr_s.imprecise);
      addr_valid      <= ev_prec | (addr_valid & ~clr_s.precise);
      if (ev_prec && !flags.precise) begin
        addr <= ev_addr;
      end
    end
  end

endmodule

// File: rtl/stb_post_buffer.sv
`timescale 1ns/1ps
module stb_post_buffer #(
  parameter int            AW           = 32,
  parameter int            DW           = 32,
  parameter logic [AW-1:0] SRAM_LO      = 'h2000_0000,
  parameter logic [AW-1:0] SRAM_HI      = 'h3FFF_FFFF,
  parameter bit            PROT_PRESENT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_ack,
  input  logic          cfg_prot_en,
  input  logic [AW-1:0] cfg_rgn_lo,
  input  logic [AW-1:0] cfg_rgn_hi,
  input  logic          cfg_rgn_buf,
  output logic          bus_valid,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  input  logic          bus_ready,
  input  logic          bus_err,
  input  logic [1:0]    flt_clr,
  output logic          flt_precise,
  output logic          flt_imprecise,
  output logic [AW-1:0] flt_addr,
  output logic          flt_addr_valid,
  output logic          fault_pulse
);

  logic          attr_buf;
  logic          attr_mask;
  logic          ev_prec;
  logic          ev_imp;
  logic [AW-1:0] ev_addr;

  stb_attr_lookup #(
    .AW(AW), .SRAM_LO(SRAM_LO), .SRAM_HI(SRAM_HI), .PROT_PRESENT(PROT_PRESENT)
  ) attr_i (
    .addr       (st_addr),
    .prot_en    (cfg_prot_en),
    .rgn_lo     (cfg_rgn_lo),
    .rgn_hi     (cfg_rgn_hi),
    .rgn_buf    (cfg_rgn_buf),
    .buf_attr   (attr_buf),
    .err_masked (attr_mask)
  );

  stb_drain_ctrl #(.AW(AW), .DW(DW)) drain_i (
    .clk       (clk),
    .rst       (rst),
    .st_valid  (st_valid),
    .st_addr   (st_addr),
    .st_data   (st_data),
    .attr_buf  (attr_buf),
    .attr_mask (attr_mask),
    .st_ack    (st_ack),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .ev_prec   (ev_prec),
    .ev_imp    (ev_imp),
    .ev_addr   (ev_addr)
  );

  stb_fault_log #(.AW(AW)) flog_i (
    .clk        (clk),
    .rst        (rst),
    .ev_prec    (ev_prec),
    .ev_imp     (ev_imp),
    .ev_addr    (ev_addr),
    .clr        (flt_clr),
    .prec       (flt_precise),
    .imp        (flt_imprecise),
    .addr       (flt_addr),
    .addr_valid (flt_addr_valid),
    .pulse      (fault_pulse)
  );

endmodule

// File: rtl/stb_post_buffer_chk.sv
`timescale 1ns/1ps
module stb_post_buffer_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          st_ack,
  input logic          bus_valid,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_data,
  input logic          bus_ready,
  input logic [1:0]    flt_clr,
  input logic          flt_precise,
  input logic          flt_imprecise,
  input logic [AW-1:0] flt_addr,
  input logic          flt_addr_valid,
  input logic          fault_pulse
);

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data)); // R6

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    st_ack |=> !st_ack); // R12

  AST_PREC_STICKY: assert property (@(posedge clk) disable iff (rst)
    flt_precise && !flt_clr[0] |=> flt_precise && $stable(flt_addr)); // R11

  AST_IMP_STICKY: assert property (@(posedge clk) disable iff (rst)
    flt_imprecise && !flt_clr[1] |=> flt_imprecise); // R11

  AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    fault_pulse |-> (flt_precise || flt_imprecise)); // R10

  AST_PREC_ADDR: assert property (@(posedge clk) disable iff (rst)
    $rose(flt_precise) |-> flt_addr_valid); // R8

  AST_IMP_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    $rose(flt_imprecise) && !flt_precise |-> !flt_addr_valid); // R7

endmodule

bind stb_post_buffer stb_post_buffer_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .st_ack         (st_ack),
  .bus_valid      (bus_valid),
  .bus_addr       (bus_addr),
  .bus_data       (bus_data),
  .bus_ready      (bus_ready),
  .flt_clr        (flt_clr),
  .flt_precise    (flt_precise),
  .flt_imprecise  (flt_imprecise),
  .flt_addr       (flt_addr),
  .flt_addr_valid (flt_addr_valid),
  .fault_pulse    (fault_pulse)
);

// File: tb/stb_post_buffer_tb_top.sv
`timescale 1ns/1ps
module stb_post_buffer_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          st_ack;
  logic          cfg_prot_en = 1'b0;
  logic [AW-1:0] cfg_rgn_lo = '0;
  logic [AW-1:0] cfg_rgn_hi = '0;
  logic          cfg_rgn_buf = 1'b0;
  logic          bus_valid;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic          bus_ready = 1'b0;
  logic          bus_err = 1'b0;
  logic [1:0]    flt_clr = 2'b00;
  logic          flt_precise;
  logic          flt_imprecise;
  logic [AW-1:0] flt_addr;
  logic          flt_addr_valid;
  logic          fault_pulse;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  // Reference model of the fault status
  logic          m_prec = 1'b0;
  logic          m_imp  = 1'b0;
  logic [AW-1:0] m_addr = '0;

  always #10 clk = ~clk;

  stb_post_buffer dut_i (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_ack(st_ack), .cfg_prot_en(cfg_prot_en), .cfg_rgn_lo(cfg_rgn_lo),
    .cfg_rgn_hi(cfg_rgn_hi), .cfg_rgn_buf(cfg_rgn_buf), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_ready(bus_ready), .bus_err(bus_err),
    .flt_clr(flt_clr), .flt_precise(flt_precise), .flt_imprecise(flt_imprecise),
    .flt_addr(flt_addr), .flt_addr_valid(flt_addr_valid), .fault_pulse(fault_pulse)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic in_sram(input logic [AW-1:0] a);
    return (a >= 32'h2000_0000) && (a <= 32'h3FFF_FFFF);
  endfunction

  function automatic logic exp_buf(input logic [AW-1:0] a);
    if (cfg_prot_en && a >= cfg_rgn_lo && a <= cfg_rgn_hi) return cfg_rgn_buf; // R3
    return in_sram(a); // R2
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_flags(input string tag);
    check({31'd0, flt_precise}, {31'd0, m_prec}, {tag, " precise flag"});
    check({31'd0, flt_imprecise}, {31'd0, m_imp}, {tag, " imprecise flag"});
    check({31'd0, flt_addr_valid}, {31'd0, m_prec}, {tag, " addr valid"});
    if (m_prec) check(flt_addr, m_addr, {tag, " fault addr"});
  endtask

  // One store; lat = stalled bus cycles before bus_ready; clr = strobe on completion cycle
  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic err, input int lat, input logic [1:0] clr);
    logic b;
    logic eff;
    b = exp_buf(a);
    st_valid = 1'b1; st_addr = a; st_data = d;
    tick();
    check({31'd0, bus_valid}, 32'd1, "R4 bus_valid after capture");
    check(bus_addr, a, "R6 bus_addr");
    check(bus_data, d, "R6 bus_data");
    check({31'd0, st_ack}, {31'd0, b}, b ? "R4 posted ack" : "R5 held no ack");
    if (b) st_valid = 1'b0;
    for (int i = 0; i < lat; i++) begin
      tick();
      check({31'd0, st_ack}, 32'd0, b ? "R12 ack single" : "R5 held stalled");
      check({31'd0, bus_valid}, 32'd1, "R6 bus_valid held");
    end
    bus_ready = 1'b1; bus_err = err; flt_clr = clr;
    tick();
    bus_ready = 1'b0; bus_err = 1'b0; flt_clr = 2'b00;
    if (!b) st_valid = 1'b0;
    eff = err && !in_sram(a); // R9
    if (eff && !b && !m_prec) m_addr = a;
    m_prec = (eff && !b) | (m_prec & ~clr[0]); // R8 R11
    m_imp  = (eff && b)  | (m_imp & ~clr[1]);  // R7 R11
    check({31'd0, st_ack}, {31'd0, !b}, b ? "R4 no late ack" : "R5 ack after completion");
    check({31'd0, bus_valid}, 32'd0, "R6 bus_valid drops");
    check({31'd0, fault_pulse}, {31'd0, eff}, "R10 fault pulse");
    check_flags(b ? "R7" : "R8");
    tick();
    check({31'd0, st_ack}, 32'd0, "R12 idle ack low");
    check({31'd0, fault_pulse}, 32'd0, "R10 pulse one cycle");
  endtask

  task automatic clear(input logic [1:0] c);
    flt_clr = c;
    tick();
    flt_clr = 2'b00;
    m_prec = m_prec & ~c[0];
    m_imp  = m_imp & ~c[1];
    check_flags("R11 clear");
  endtask

  logic [AW-1:0] addrs [4];

  initial begin
    addrs[0] = 32'h2000_0100;
    addrs[1] = 32'h4000_1000;
    addrs[2] = 32'h0800_0040;
    addrs[3] = 32'h5FFF_FFFC;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check({31'd0, st_ack}, 32'd0, "R1 ack in reset");
    check({31'd0, bus_valid}, 32'd0, "R1 bus_valid in reset");
    rst = 1'b0;
    @(negedge clk);
    check({31'd0, st_ack}, 32'd0, "R1 ack after reset");
    check({31'd0, bus_valid}, 32'd0, "R1 bus_valid after reset");
    check({31'd0, fault_pulse}, 32'd0, "R1 pulse after reset");
    check_flags("R1");

    // Sweep: protection on/off, region placement, region attribute, address, error
    for (int pe = 0; pe < 2; pe++) begin
      for (int rs = 0; rs < 2; rs++) begin
        for (int rb = 0; rb < 2; rb++) begin
          cfg_prot_en = pe[0];
          cfg_rgn_lo  = rs[0] ? 32'h2000_0000 : 32'h4000_0000;
          cfg_rgn_hi  = rs[0] ? 32'h3FFF_FFFF : 32'h5FFF_FFFF;
          cfg_rgn_buf = rb[0];
          for (int ai = 0; ai < 4; ai++) begin
            for (int e = 0; e < 2; e++) begin
              do_store(addrs[ai], {pe[7:0], rs[7:0], rb[7:0], ai[3:0], e[3:0]},
                       e[0], (ai + e + rb) % 3, 2'b00);
            end
          end
          clear(2'b11);
        end
      end
    end

    // R11: sticky precise address keeps the first fault
    cfg_prot_en = 1'b0;
    do_store(32'h4000_0010, 32'hAAAA_0001, 1'b1, 1, 2'b00);
    do_store(32'h4000_0020, 32'hAAAA_0002, 1'b1, 0, 2'b00);
    check(flt_addr, 32'h4000_0010, "R11 first address kept");
    clear(2'b01);

    // R11: set beats clear in the same cycle
    do_store(32'h4000_0030, 32'hBBBB_0001, 1'b1, 1, 2'b01);
    check({31'd0, flt_precise}, 32'd1, "R11 precise set beats clear");
    cfg_prot_en = 1'b1; cfg_rgn_lo = 32'h4000_0000; cfg_rgn_hi = 32'h5FFF_FFFF; cfg_rgn_buf = 1'b1;
    do_store(32'h4000_0040, 32'hBBBB_0002, 1'b1, 2, 2'b10);
    check({31'd0, flt_imprecise}, 32'd1, "R11 imprecise set beats clear");
    clear(2'b11);

    // R6: second store arrives while a posted store drains
    cfg_prot_en = 1'b0;
    st_valid = 1'b1; st_addr = 32'h2000_0200; st_data = 32'h1111_1111;
    tick();
    check({31'd0, st_ack}, 32'd1, "R4 first store posted");
    st_addr = 32'h4000_0200; st_data = 32'h2222_2222;
    for (int i = 0; i < 3; i++) begin
      tick();
      check({31'd0, st_ack}, 32'd0, "R6 second store stalled");
      check(bus_addr, 32'h2000_0200, "R6 first store still on bus");
    end
    bus_ready = 1'b1;
    tick();
    bus_ready = 1'b0;
    check({31'd0, bus_valid}, 32'd0, "R6 entry freed");
    tick();
    check({31'd0, bus_valid}, 32'd1, "R6 second store captured");
    check(bus_addr, 32'h4000_0200, "R6 program order addr");
    check(bus_data, 32'h2222_2222, "R6 program order data");
    check({31'd0, st_ack}, 32'd0, "R5 second store held");
    bus_ready = 1'b1;
    tick();
    bus_ready = 1'b0;
    check({31'd0, st_ack}, 32'd1, "R5 second store acked");
    st_valid = 1'b0;
    tick();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule